// File: doc/BRIEF.md
# PHY Test-Port Register Access Master

This block turns single register requests into the slow, bit-level handshake of a PHY test port. The port has an enable line, a test clock, an 8-bit data-in bus and an 8-bit data-out bus. Every accepted request starts with an address phase. The address is presented with the enable line high and is strobed by one test-clock pulse. A write then runs a data phase with the enable line low. A read instead waits a programmable settling time and then samples the data-out bus.

Requests carry register and value fields that are wider than the port. A request whose register, or whose write value, does not fit in 8 bits is refused with an error and never reaches the port. The block handles one access at a time. It holds `busy` high for the whole access and ends every request with a one-cycle `done` pulse. On a read, that pulse comes with the data that was returned.

Top module: `tport_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `err`, `tp_en`, `tp_clk`, `tp_din` and `rd_data` are all zero.
- R2: A request (`req_valid` high at a clock edge) is accepted only while `busy` is low. A request presented while `busy` is high is ignored and reaches neither the port nor the PHY registers.
- R3: An accepted request is refused if `req_addr` is above 0xFF, or if it is a write (`req_write`=1) with `req_wdata` above 0xFF. The refusal is a single cycle with `busy`, `done` and `err` all high, and the port lines stay at zero throughout. A read ignores `req_wdata` entirely.
- R4: The address phase places the address on `tp_din` with `tp_en` high. It then holds `tp_clk` low for H cycles, high for H cycles and low for H cycles, so the PHY sees exactly one rising test-clock edge with the enable line high.
- R5: A write follows the address phase with a data phase. The value is on `tp_din` with `tp_en` low, and the same low/high/low pattern of H cycles each gives the PHY one more rising edge, which stores the value.
- R6: A read follows the address phase with `tp_en` low for W cycles and no test-clock edge. `tp_dout` is captured on the last of these cycles and presented on `rd_data` while `done` is high.
- R7: `busy` rises in the cycle after acceptance. `done` is high for exactly one cycle, the last busy cycle, with `err` low for every accepted, in-range request. A write lasts 6H+1 busy cycles and a read lasts 3H+W+1 busy cycles.
- R8: H is `cfg_phase` and W is `cfg_wait`, both sampled when the request is accepted. A value of zero counts as one. Changing either input during an access has no effect on that access.
- R9: `tp_din` and `tp_en` never change in the cycle where `tp_clk` rises or falls. The enable line only falls while `tp_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_phase | input | PHASE_W | Test-clock phase length H in system clocks (0 counts as 1) |
| cfg_wait | input | WAIT_W | Read settling time W in system clocks (0 counts as 1) |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | REQ_W | Register number; values above 0xFF are refused |
| req_wdata | input | REQ_W | Write value; above 0xFF is refused on writes |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with done when the request was refused |
| rd_data | output | DATA_W | Read result, valid while done is high after a read |
| tp_en | output | 1 | Test-port enable, high during the address phase |
| tp_clk | output | 1 | Test-port clock |
| tp_din | output | DATA_W | Test-port data-in bus |
| tp_dout | input | DATA_W | Test-port data-out bus from the PHY |

## Verification
A sequencer that skips a state, or loads the wrong phase length, changes the length of the access. That shows up at `done` in the same access, because the count of busy cycles, the number of test-clock cycles spent high and the number of cycles with the enable line high all shift. A wrong address or data latch stores a value in the wrong PHY register. That stays hidden until the same register is read back, so the bench first writes every register and then reads every one of them. A refusal that leaks onto the port, or a request taken while busy, corrupts a register that a later read checks.

// File: rtl/tport_pkg.sv
package tport_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_REJECT,
      ST_ADR_SETUP,
      ST_ADR_HIGH,
      ST_ADR_LOW,
      ST_DAT_SETUP,
      ST_DAT_HIGH,
      ST_DAT_LOW,
      ST_RD_WAIT,
      ST_FINISH
   } tport_state_e;

   function automatic logic is_addr_state(input tport_state_e s);
      return (s == ST_ADR_SETUP) || (s == ST_ADR_HIGH) || (s == ST_ADR_LOW);
   endfunction

   function automatic logic is_data_state(input tport_state_e s);
      return (s == ST_DAT_SETUP) || (s == ST_DAT_HIGH) || (s == ST_DAT_LOW);
   endfunction

endpackage

// File: rtl/tport_range_chk.sv
module tport_range_chk #(
   parameter int REQ_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic [REQ_W-1:0] addr,
   input  logic [REQ_W-1:0] wdata,
   input  logic             is_write,
   output logic             in_range
);

   generate
      if (REQ_W > DATA_W) begin : g_wide
         logic addr_over;
         logic data_over;
         logic unused_low;
         assign addr_over  = |addr[REQ_W-1:DATA_W];
         assign data_over  = |wdata[REQ_W-1:DATA_W];
         assign in_range   = !addr_over && !(is_write && data_over);
         assign unused_low = ^{addr[DATA_W-1:0], wdata[DATA_W-1:0]};
      end else begin : g_exact
         logic unused_all;
         assign in_range   = 1'b1;
         assign unused_all = ^{addr, wdata, is_write};
      end
   endgenerate

endmodule

// File: rtl/tport_timer.sv
module tport_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/tport_seq.sv
module tport_seq
   import tport_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int PHASE_W = 6,
   parameter int WAIT_W  = 10,
   parameter int CNT_W   = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] cfg_phase,
   input  logic [WAIT_W-1:0]  cfg_wait,
   input  logic               start,
   input  logic               start_write,
   input  logic               start_ok,
   input  logic [DATA_W-1:0]  start_addr,
   input  logic [DATA_W-1:0]  start_data,
   input  logic               expired,
   output tport_state_e       state,
   output logic               tmr_load,
   output logic [CNT_W-1:0]   tmr_val,
   output logic [DATA_W-1:0]  addr_q,
   output logic [DATA_W-1:0]  data_q
);

   tport_state_e       state_q;
   tport_state_e       state_d;
   logic [PHASE_W-1:0] phase_m1_in;
   logic [WAIT_W-1:0]  wait_m1_in;
   logic [PHASE_W-1:0] phase_m1_q;
   logic [WAIT_W-1:0]  wait_m1_q;
   logic               write_q;
   logic               take;

   assign phase_m1_in = (cfg_phase == '0) ? '0 : cfg_phase - 1'b1;
   assign wait_m1_in  = (cfg_wait == '0) ? '0 : cfg_wait - 1'b1;
   assign take        = (state_q == ST_IDLE) && start;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = CNT_W'(phase_m1_q);
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(phase_m1_in);
               state_d  = start_ok ? ST_ADR_SETUP : ST_REJECT;
            end
         end
         ST_REJECT: state_d = ST_IDLE;
         ST_ADR_SETUP: begin
            if (expired) begin
               tmr_load = 1'b1;
               state_d  = ST_ADR_HIGH;
            end
         end
         ST_ADR_HIGH: begin
            if (expired) begin
               tmr_load = 1'b1;
               state_d  = ST_ADR_LOW;
            end
         end
         ST_ADR_LOW: begin
            if (expired) begin
               tmr_load = 1'b1;
               if (write_q) begin
                  state_d = ST_DAT_SETUP;
               end else begin
                  tmr_val = CNT_W'(wait_m1_q);
                  state_d = ST_RD_WAIT;
               end
            end
         end
         ST_DAT_SETUP: begin
            if (expired) begin
               tmr_load = 1'b1;
               state_d  = ST_DAT_HIGH;
            end
         end
         ST_DAT_HIGH: begin
            if (expired) begin
               tmr_load = 1'b1;
               state_d  = ST_DAT_LOW;
            end
         end
         ST_DAT_LOW: if (expired) state_d = ST_FINISH;
         ST_RD_WAIT: if (expired) state_d = ST_FINISH;
         ST_FINISH:  state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_m1_q <= '0;
         wait_m1_q  <= '0;
         write_q    <= 1'b0;
         addr_q     <= '0;
         data_q     <= '0;
      end else begin
         state_q <= state_d;
         if (take) begin
            phase_m1_q <= phase_m1_in;
            wait_m1_q  <= wait_m1_in;
            write_q    <= start_write;
            addr_q     <= start_addr;
            data_q     <= start_data;
         end
      end
   end

   assign state = state_q;

endmodule

// File: rtl/tport_pindrv.sv
module tport_pindrv
   import tport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  tport_state_e      state,
   input  logic [DATA_W-1:0] addr_q,
   input  logic [DATA_W-1:0] data_q,
   output logic              tp_en,
   output logic              tp_clk,
   output logic [DATA_W-1:0] tp_din,
   output logic              busy,
   output logic              done,
   output logic              err
);

   always_comb begin
      tp_en  = is_addr_state(state);
      tp_clk = (state == ST_ADR_HIGH) || (state == ST_DAT_HIGH);
      if (is_addr_state(state)) begin
         tp_din = addr_q;
      end else if (is_data_state(state)) begin
         tp_din = data_q;
      end else begin
         tp_din = '0;
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_FINISH) || (state == ST_REJECT);
   assign err  = (state == ST_REJECT);

endmodule

// File: rtl/tport_master.sv
module tport_master
   import tport_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int REQ_W   = 16,
   parameter int PHASE_W = 6,
   parameter int WAIT_W  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] cfg_phase,
   input  logic [WAIT_W-1:0]  cfg_wait,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [REQ_W-1:0]   req_addr,
   input  logic [REQ_W-1:0]   req_wdata,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic [DATA_W-1:0]  rd_data,
   output logic               tp_en,
   output logic               tp_clk,
   output logic [DATA_W-1:0]  tp_din,
   input  logic [DATA_W-1:0]  tp_dout
);

   localparam int CNT_W = (PHASE_W > WAIT_W) ? PHASE_W : WAIT_W;

   generate
      if (REQ_W < DATA_W) begin : g_bad_req_w
         $error("tport_master: REQ_W must be at least DATA_W");
      end
      if (PHASE_W < 1 || WAIT_W < 1) begin : g_bad_cnt_w
         $error("tport_master: PHASE_W and WAIT_W must be positive");
      end
   endgenerate

   tport_state_e      state;
   logic              in_range;
   logic              expired;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] rd_q;

   tport_range_chk #(.REQ_W(REQ_W), .DATA_W(DATA_W)) u_range (
      .addr     (req_addr),
      .wdata    (req_wdata),
      .is_write (req_write),
      .in_range (in_range)
   );

   tport_seq #(
      .DATA_W  (DATA_W),
      .PHASE_W (PHASE_W),
      .WAIT_W  (WAIT_W),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_phase   (cfg_phase),
      .cfg_wait    (cfg_wait),
      .start       (req_valid),
      .start_write (req_write),
      .start_ok    (in_range),
      .start_addr  (req_addr[DATA_W-1:0]),
      .start_data  (req_wdata[DATA_W-1:0]),
      .expired     (expired),
      .state       (state),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .addr_q      (addr_q),
      .data_q      (data_q)
   );

   tport_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (expired)
   );

   tport_pindrv #(.DATA_W(DATA_W)) u_pins (
      .state  (state),
      .addr_q (addr_q),
      .data_q (data_q),
      .tp_en  (tp_en),
      .tp_clk (tp_clk),
      .tp_din (tp_din),
      .busy   (busy),
      .done   (done),
      .err    (err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if ((state == ST_RD_WAIT) && expired) begin
         rd_q <= tp_dout;
      end
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/tport_master_chk.sv
module tport_master_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              tp_en,
   input logic              tp_clk,
   input logic [DATA_W-1:0] tp_din
);

   AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!tp_en && !tp_clk && !done)); // R1

   AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy); // R2

   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !tp_en && !tp_clk)); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R7

   AST_DIN_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tp_clk) |-> ($stable(tp_din) && $stable(tp_en))); // R9

   AST_DIN_STABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tp_clk) |-> ($stable(tp_din) && $stable(tp_en))); // R9

   AST_EN_DROP_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tp_en) |-> !tp_clk); // R9

endmodule

bind tport_master tport_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .tp_en     (tp_en),
   .tp_clk    (tp_clk),
   .tp_din    (tp_din)
);

// File: tb/tport_master_tb.sv
module tport_master_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int RW = 16;
   localparam int PW = 6;
   localparam int WW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] cfg_phase = '0;
   logic [WW-1:0] cfg_wait = '0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [RW-1:0] req_addr = '0;
   logic [RW-1:0] req_wdata = '0;
   logic          busy, done, err;
   logic [DW-1:0] rd_data;
   logic          tp_en, tp_clk;
   logic [DW-1:0] tp_din;
   logic [DW-1:0] tp_dout;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tport_master #(.DATA_W(DW), .REQ_W(RW), .PHASE_W(PW), .WAIT_W(WW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_phase(cfg_phase), .cfg_wait(cfg_wait),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
      .rd_data(rd_data), .tp_en(tp_en), .tp_clk(tp_clk), .tp_din(tp_din),
      .tp_dout(tp_dout)
   );

   // PHY responder: enable high at a rising test clock latches the
   // register number, enable low stores the value into that register.
   logic [7:0] phy_mem [256];
   logic [7:0] phy_sel = 8'h00;
   always @(posedge tp_clk) begin
      if (tp_en) phy_sel <= tp_din;
      else       phy_mem[phy_sel] <= tp_din;
   end
   assign tp_dout = phy_mem[phy_sel];

   // Port activity monitor, sampled at system clock edges.
   int   rise_cnt = 0;
   int   hi_cnt   = 0;
   int   en_cnt   = 0;
   logic clk_prev = 1'b0;
   always @(posedge clk) begin
      if (tp_clk && !clk_prev) rise_cnt++;
      if (tp_clk) hi_cnt++;
      if (tp_en)  en_cnt++;
      clk_prev = tp_clk;
   end

   int exp_mem [256];

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One request. hold: keep req_valid high during the access with another
   // register and value. alt: cfg_phase/cfg_wait value applied mid-access (-1 none).
   task automatic run(input bit wr, input int addr, input int data, input int h,
                      input int w, input bit hold, input int alt);
      int  he, we, cyc, r0, h0, e0, exp_cyc;
      bit  ok;
      he = (h == 0) ? 1 : h;
      we = (w == 0) ? 1 : w;
      ok = (addr <= 255) && (!wr || data <= 255);
      @(negedge clk);
      cfg_phase = PW'(h);
      cfg_wait  = WW'(w);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = RW'(addr);
      req_wdata = RW'(data);
      r0 = rise_cnt; h0 = hi_cnt; e0 = en_cnt;
      @(negedge clk);
      cyc = 1;
      if (hold) begin
         req_addr  = RW'((addr + 1) & 255);
         req_wdata = RW'(data ^ 8'h5A);
      end else begin
         req_valid = 1'b0;
      end
      if (alt >= 0) begin
         cfg_phase = PW'(alt);
         cfg_wait  = WW'(alt);
      end
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      if (!ok)     exp_cyc = 1;
      else if (wr) exp_cyc = 6*he + 1;
      else         exp_cyc = 3*he + we + 1;
      check("R7", "cycles to done", cyc, exp_cyc);
      check("R3", "err", int'(err), ok ? 0 : 1);
      if (ok && !wr) check("R6", "read data", int'(rd_data), exp_mem[addr]);
      @(negedge clk);
      check("R7", "busy after done", int'(busy), 0);
      check(wr ? "R5" : "R4", "test clock rises", rise_cnt - r0, !ok ? 0 : (wr ? 2 : 1));
      check("R8", "test clock high cycles", hi_cnt - h0, !ok ? 0 : (wr ? 2*he : he));
      check("R4", "enable high cycles", en_cnt - e0, ok ? 3*he : 0);
      if (ok && wr) exp_mem[addr] = data;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         phy_mem[i] = 8'(~i);
         exp_mem[i] = (~i) & 255;
      end
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", int'(busy), 0);
      check("R1", "tp_en in reset", int'(tp_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy", int'(busy), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "err", int'(err), 0);
      check("R1", "tp_clk", int'(tp_clk), 0);
      check("R1", "tp_din", int'(tp_din), 0);
      check("R1", "rd_data", int'(rd_data), 0);

      // R5 R6: every register written then read back, shortest timing
      for (int a = 0; a < 256; a++) run(1'b1, a, (a*29 + 7) & 255, 1, 1, 1'b0, -1);
      for (int a = 0; a < 256; a++) run(1'b0, a, 0, 1, 1, 1'b0, -1);

      // R8: phase and wait sweep, zero counts as one
      for (int h = 0; h <= 4; h++) begin
         for (int w = 0; w <= 7; w += 3) begin
            run(1'b1, 16*h + w, (h*53 + w*11) & 255, h, w, 1'b0, -1);
            run(1'b0, 16*h + w, 0, h, w, 1'b0, -1);
         end
      end

      // R8: configuration changes during an access are ignored
      run(1'b1, 8'h40, 8'hC3, 3, 2, 1'b0, 1);
      run(1'b0, 8'h40, 0, 2, 5, 1'b0, 9);

      // R3: refusals leave the PHY untouched
      run(1'b1, 16'h0100, 8'h11, 2, 1, 1'b0, -1);
      run(1'b0, 16'h01AB, 0, 2, 1, 1'b0, -1);
      run(1'b1, 8'h10, 16'h0100, 2, 1, 1'b0, -1);
      run(1'b0, 8'h10, 0, 1, 1, 1'b0, -1);
      run(1'b1, 16'hFFFF, 16'hFFFF, 1, 1, 1'b0, -1);
      run(1'b0, 8'h00, 0, 1, 1, 1'b0, -1);
      // R3: a read ignores an oversized write value
      run(1'b0, 8'hFF, 16'hFFFF, 1, 2, 1'b0, -1);

      // R2: a request held during busy is not taken
      run(1'b1, 8'h20, 8'h55, 2, 1, 1'b1, -1);
      run(1'b0, 8'h21, 0, 1, 1, 1'b0, -1);
      run(1'b0, 8'h20, 0, 1, 1, 1'b0, -1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule